// File: doc/BRIEF.md
# Contactless Type-B frame serializer

This block turns a stream of bytes into the serial bit line of a Type B proximity-card transmitter. Bytes arrive on a valid/ready input. The block frames them into characters. Each character is a low start bit, eight data bits sent least significant bit first, and a high stop bit. After each character the line is held high for a programmable extra guard time. A frame may open with a start-of-frame pattern (a long low period, then a high period) and may close with an end-of-frame low period. Either one can be switched off. Subcarrier generation and load modulation are left to the stage that follows.

All timing is counted in ticks of a carrier-cycle clock enable. One elementary time unit (etu) is a parameter that defaults to 128 ticks. The start and end patterns come in three sizes: the shortest standard size, the longest standard size, and an adjusted size that moves the low/high boundary by a parameter number of ticks (default 8). The frame ends with the byte marked as last. The line rests high between frames. A busy flag covers the whole frame.

Top module: `tbx_frame_ser`

## Requirements
- R1: While reset is asserted and right after it, `tx_out` is 1, `busy` is 0, `in_ready` is 1 and `cfg_err` is 0.
- R2: Each character is a start bit at 0, then the 8 data bits least significant bit first, then a stop bit at 1. Each bit lasts one etu (128 ticks by default).
- R3: After every stop bit, including the last one, the line stays at 1 for `cfg_egt` etu. The codes are 2'b00 for 0, 2'b01 for 1, 2'b10 for 2 and 2'b11 for 3.
- R4: With `cfg_wide`=0 and `cfg_adjust`=0, the start pattern is 10 etu low then 2 etu high, and the end pattern is 10 etu low.
- R5: With `cfg_wide`=1 and `cfg_adjust`=0, the start pattern is 11 etu low then 3 etu high, and the end pattern is 11 etu low.
- R6: With `cfg_wide`=1 and `cfg_adjust`=1, the start low lasts 11 etu minus 8 ticks, the start high lasts 2 etu plus 8 ticks, and the end low lasts 11 etu minus 8 ticks.
- R7: `cfg_adjust`=1 with `cfg_wide`=0 is not a valid setting. The block then uses the R4 lengths, and `cfg_err` reads 1 from the clock edge after the setting appears until the edge after it is removed.
- R8: With `cfg_no_sof`=1, the start bit of the first character begins on the clock edge that accepts the first byte, with no start pattern before it.
- R9: With `cfg_no_eof`=1, the frame ends after the guard time of the last character. No end pattern is sent, and the line returns to idle high.
- R10: `busy` is 1 from the first low period of a frame until its last period ends. When `busy` is 0, `tx_out` is 1.
- R11: `in_ready` is 1 when the block is idle. Inside a frame it is 1 only during a stop bit or guard time, and only while no byte is held and the last byte has not been taken. It is never 1 while the line is driven low.
- R12: Periods advance only on clock edges where `fc_en` is 1. A period of N ticks lasts exactly N enabled edges, whatever the gaps between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fc_en | input | 1 | One-cycle enable per carrier tick |
| cfg_no_sof | input | 1 | 1 suppresses the start-of-frame pattern |
| cfg_no_eof | input | 1 | 1 suppresses the end-of-frame pattern |
| cfg_wide | input | 1 | Start/end pattern width select (1 = long) |
| cfg_adjust | input | 1 | Tick-offset adjusted start/end sizing |
| cfg_egt | input | 2 | Guard time after each character, in etu |
| in_valid | input | 1 | Byte available |
| in_data | input | 8 | Byte to send |
| in_last | input | 1 | Byte is the last one of the frame |
| in_ready | output | 1 | Byte is accepted on this edge when valid |
| tx_out | output | 1 | Serial line, idle high |
| busy | output | 1 | Frame in progress |
| cfg_err | output | 1 | Invalid sizing setting applied |

## Verification
The first period of a frame shows on the line in the cycle after the edge that accepts the first byte. Every later level change comes on the edge that carries the last enabled tick of the current period. The bench therefore samples at the falling edge, compares the line with the head of an expected tick list built from the requirements, and drops that entry only when the enable it has just driven for the coming edge is 1. This keeps the comparison exact under both steady and randomly gapped enables. `cfg_err` is registered, so it is due one edge after a setting change, and the bench reads it two edges later.

// File: rtl/tbx_pkg.sv
package tbx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SOF_LO,
    ST_SOF_HI,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_EGT,
    ST_WAIT,
    ST_EOF_LO
  } ser_state_e;
endpackage

// File: rtl/tbx_seg_len.sv
module tbx_seg_len
  import tbx_pkg::*;
#(
  parameter int ETU_FC = 128,
  parameter int ADJ_FC = 8,
  parameter int CW     = 11
) (
  input  ser_state_e      seg,
  input  logic            cfg_wide,
  input  logic            cfg_adjust,
  input  logic [1:0]      cfg_egt,
  output logic [CW-1:0]   seg_len,
  output logic            cfg_bad
);
  localparam logic [CW-1:0] ETU_W  = CW'(ETU_FC);
  localparam logic [CW-1:0] LO_MIN = CW'(10 * ETU_FC);
  localparam logic [CW-1:0] LO_MAX = CW'(11 * ETU_FC);
  localparam logic [CW-1:0] LO_ADJ = CW'(11 * ETU_FC - ADJ_FC);
  localparam logic [CW-1:0] HI_MIN = CW'(2 * ETU_FC);
  localparam logic [CW-1:0] HI_MAX = CW'(3 * ETU_FC);
  localparam logic [CW-1:0] HI_ADJ = CW'(2 * ETU_FC + ADJ_FC);

  logic          use_adj;
  logic [CW-1:0] lo_len;
  logic [CW-1:0] hi_len;
  logic [CW-1:0] egt_len;

  // adjust only takes effect with the long width; otherwise fall back to min
  assign use_adj = cfg_adjust & cfg_wide;
  assign cfg_bad = cfg_adjust & ~cfg_wide;

  always_comb begin
    if (use_adj) begin
      lo_len = LO_ADJ;
      hi_len = HI_ADJ;
    end else if (cfg_wide) begin
      lo_len = LO_MAX;
      hi_len = HI_MAX;
    end else begin
      lo_len = LO_MIN;
      hi_len = HI_MIN;
    end
    egt_len = CW'(cfg_egt) * ETU_W;
  end

  always_comb begin
    unique case (seg)
      ST_SOF_LO, ST_EOF_LO: seg_len = lo_len;
      ST_SOF_HI:            seg_len = hi_len;
      ST_EGT:               seg_len = egt_len;
      default:              seg_len = ETU_W;
    endcase
  end
endmodule

// File: rtl/tbx_tick_timer.sv
module tbx_tick_timer #(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fc_en,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expire
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load) begin
      cnt_d = load_val;
    end else if (fc_en && (cnt_q != '0)) begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign expire = fc_en && (cnt_q == CW'(1));

  // a zero-length period would never expire; the guard period is skipped instead
  AST_TMR_LOAD_NZ: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> (load_val != '0)); // R3
endmodule

// File: rtl/tbx_frame_ser.sv
module tbx_frame_ser
  import tbx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ETU_FC = 128,
  parameter int ADJ_FC = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fc_en,
  input  logic              cfg_no_sof,
  input  logic              cfg_no_eof,
  input  logic              cfg_wide,
  input  logic              cfg_adjust,
  input  logic [1:0]        cfg_egt,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_last,
  output logic              in_ready,
  output logic              tx_out,
  output logic              busy,
  output logic              cfg_err
);
  localparam int CW = $clog2(12 * ETU_FC + ADJ_FC + 1);
  localparam int IW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [IW-1:0] LAST_BIT = IW'(DATA_W - 1);

  ser_state_e        state_q, state_d;
  logic              pend_v_q, pend_v_d;
  logic [DATA_W-1:0] pend_q, pend_d;
  logic              pend_last_q, pend_last_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              cur_last_q, cur_last_d;
  logic [IW-1:0]     idx_q, idx_d;
  logic              cfg_err_q;

  logic              accept, src_ok, take, char_done, seg_end, tmr_load, cfg_bad;
  logic [DATA_W-1:0] src_data;
  logic              src_last;
  logic [CW-1:0]     seg_len;

  tbx_seg_len #(.ETU_FC(ETU_FC), .ADJ_FC(ADJ_FC), .CW(CW)) u_len (
    .seg        (state_d),
    .cfg_wide   (cfg_wide),
    .cfg_adjust (cfg_adjust),
    .cfg_egt    (cfg_egt),
    .seg_len    (seg_len),
    .cfg_bad    (cfg_bad)
  );

  assign tmr_load = (state_d != state_q) || ((state_q == ST_DATA) && seg_end);

  tbx_tick_timer #(.CW(CW)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .fc_en    (fc_en),
    .load     (tmr_load),
    .load_val (seg_len),
    .expire   (seg_end)
  );

  // input handshake
  assign in_ready = (state_q == ST_IDLE) ||
                    (((state_q == ST_STOP) || (state_q == ST_EGT) || (state_q == ST_WAIT))
                     && !pend_v_q && !cur_last_q);
  assign accept   = in_valid && in_ready;
  assign src_ok   = pend_v_q || accept;
  assign src_data = pend_v_q ? pend_q : in_data;
  assign src_last = pend_v_q ? pend_last_q : in_last;

  // next state
  always_comb begin
    state_d   = state_q;
    take      = 1'b0;
    char_done = 1'b0;
    unique case (state_q)
      ST_IDLE: if (accept) begin
        if (cfg_no_sof) begin
          state_d = ST_START;
          take    = 1'b1;
        end else begin
          state_d = ST_SOF_LO;
        end
      end
      ST_SOF_LO: if (seg_end) state_d = ST_SOF_HI;
      ST_SOF_HI: if (seg_end) begin
        state_d = ST_START;
        take    = 1'b1;
      end
      ST_START:  if (seg_end) state_d = ST_DATA;
      ST_DATA:   if (seg_end && (idx_q == LAST_BIT)) state_d = ST_STOP;
      ST_STOP:   if (seg_end) begin
        if (cfg_egt != 2'b00) state_d = ST_EGT;
        else                  char_done = 1'b1;
      end
      ST_EGT:    if (seg_end) char_done = 1'b1;
      ST_WAIT:   if (src_ok) begin
        state_d = ST_START;
        take    = 1'b1;
      end
      ST_EOF_LO: if (seg_end) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
    if (char_done) begin
      if (cur_last_q) begin
        state_d = cfg_no_eof ? ST_IDLE : ST_EOF_LO;
      end else if (src_ok) begin
        state_d = ST_START;
        take    = 1'b1;
      end else begin
        state_d = ST_WAIT;
      end
    end
  end

  // datapath next values
  always_comb begin
    pend_v_d    = pend_v_q;
    pend_d      = pend_q;
    pend_last_d = pend_last_q;
    sh_d        = sh_q;
    cur_last_d  = cur_last_q;
    idx_d       = idx_q;
    if (take) begin
      pend_v_d   = 1'b0;
      sh_d       = src_data;
      cur_last_d = src_last;
    end else if (accept) begin
      pend_v_d    = 1'b1;
      pend_d      = in_data;
      pend_last_d = in_last;
    end
    if (state_q == ST_START) begin
      idx_d = '0;
    end else if ((state_q == ST_DATA) && seg_end) begin
      idx_d = idx_q + 1'b1;
      sh_d  = sh_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pend_v_q    <= 1'b0;
      pend_q      <= '0;
      pend_last_q <= 1'b0;
      sh_q        <= '0;
      cur_last_q  <= 1'b0;
      idx_q       <= '0;
      cfg_err_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      pend_v_q    <= pend_v_d;
      pend_q      <= pend_d;
      pend_last_q <= pend_last_d;
      sh_q        <= sh_d;
      cur_last_q  <= cur_last_d;
      idx_q       <= idx_d;
      cfg_err_q   <= cfg_bad;
    end
  end

  // line level
  always_comb begin
    unique case (state_q)
      ST_SOF_LO, ST_START, ST_EOF_LO: tx_out = 1'b0;
      ST_DATA:                        tx_out = sh_q[0];
      default:                        tx_out = 1'b1;
    endcase
  end

  assign busy    = (state_q != ST_IDLE);
  assign cfg_err = cfg_err_q;

  AST_LINE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tx_out); // R10
  AST_READY_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && busy) |-> tx_out); // R11
  AST_HOLD_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v_q && busy) |-> !in_ready); // R11
  AST_CFG_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> $past(cfg_adjust && !cfg_wide)); // R7
  AST_EGT_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EGT) |-> (cfg_egt != 2'b00)); // R3
  AST_NO_SOF: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SOF_HI) |-> !cfg_no_sof); // R8
endmodule

// File: tb/sim_tbx_frame_ser.sv
module sim_tbx_frame_ser;
  localparam int ETU      = 128;
  localparam int ADJ      = 8;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       fc_en;
  logic       cfg_no_sof, cfg_no_eof, cfg_wide, cfg_adjust;
  logic [1:0] cfg_egt;
  logic       in_valid;
  logic [7:0] in_data;
  logic       in_last;
  logic       in_ready, tx_out, busy, cfg_err;

  int  n_chk  = 0;
  int  n_fail = 0;
  int  cyc    = 0;
  bit  wd_hit = 1'b0;

  bit    exp_lvl[$];
  string exp_tag[$];

  tbx_frame_ser u0 (
    .clk(clk), .rst_n(rst_n), .fc_en(fc_en),
    .cfg_no_sof(cfg_no_sof), .cfg_no_eof(cfg_no_eof),
    .cfg_wide(cfg_wide), .cfg_adjust(cfg_adjust), .cfg_egt(cfg_egt),
    .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
    .in_ready(in_ready), .tx_out(tx_out), .busy(busy), .cfg_err(cfg_err)
  );

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic int lo_ticks(input bit wide, input bit adj);
    if (wide && adj) return 11 * ETU - ADJ;
    if (wide)        return 11 * ETU;
    return 10 * ETU;
  endfunction

  function automatic int hi_ticks(input bit wide, input bit adj);
    if (wide && adj) return 2 * ETU + ADJ;
    if (wide)        return 3 * ETU;
    return 2 * ETU;
  endfunction

  function automatic string size_tag(input bit wide, input bit adj);
    if (wide && adj) return "R6";
    if (wide)        return "R5";
    if (adj)         return "R7";
    return "R4";
  endfunction

  task automatic push(input bit lvl, input int ticks, input string tag);
    for (int i = 0; i < ticks; i++) begin
      exp_lvl.push_back(lvl);
      exp_tag.push_back(tag);
    end
  endtask

  task automatic set_cfg(input bit nsof, input bit neof, input bit wide,
                         input bit adj, input logic [1:0] egt);
    @(negedge clk);
    cfg_no_sof = nsof; cfg_no_eof = neof; cfg_wide = wide;
    cfg_adjust = adj;  cfg_egt = egt;
    @(negedge clk);
    @(negedge clk);
    check(cfg_err == (adj & ~wide), "R7", "config error flag", cfg_err, adj & ~wide);
  endtask

  task automatic run_frame(input int n, input bit gate);
    logic [7:0] bytes[4];
    int    idx = 0;
    bit    started = 1'b0;
    bit    done = 1'b0;
    int    bad_ready = 0;
    string stag = size_tag(cfg_wide, cfg_adjust);
    exp_lvl.delete();
    exp_tag.delete();
    for (int b = 0; b < 4; b++) bytes[b] = 8'($urandom);
    if (!cfg_no_sof) begin
      push(1'b0, lo_ticks(cfg_wide, cfg_adjust), gate ? "R12" : stag);
      push(1'b1, hi_ticks(cfg_wide, cfg_adjust), gate ? "R12" : stag);
    end
    for (int b = 0; b < n; b++) begin
      push(1'b0, ETU, gate ? "R12" : ((b == 0 && cfg_no_sof) ? "R8" : "R2"));
      for (int k = 0; k < 8; k++) push(bytes[b][k], ETU, gate ? "R12" : "R2");
      push(1'b1, ETU, gate ? "R12" : "R2");
      push(1'b1, int'(cfg_egt) * ETU, gate ? "R12" : "R3");
    end
    if (!cfg_no_eof) push(1'b0, lo_ticks(cfg_wide, cfg_adjust), gate ? "R12" : stag);

    while (!done) begin
      @(negedge clk);
      if (cyc > WD_LIMIT) begin
        wd_hit = 1'b1;
        check(1'b0, "R10", "watchdog expired", cyc, WD_LIMIT);
        break;
      end
      fc_en = gate ? 1'($urandom_range(0, 1)) : 1'b1;
      if (started) begin
        if (exp_lvl.size() == 0) begin
          check(tx_out == 1'b1, cfg_no_eof ? "R9" : "R10", "line after frame", tx_out, 1);
          check(busy == 1'b0, "R10", "busy after frame", busy, 0);
          done = 1'b1;
        end else begin
          check(tx_out == exp_lvl[0], exp_tag[0], "line level", tx_out, exp_lvl[0]);
          check(busy == 1'b1, "R10", "busy inside frame", busy, 1);
          if (exp_lvl[0] == 1'b0 && in_ready) bad_ready++;
          if (fc_en) begin
            void'(exp_lvl.pop_front());
            void'(exp_tag.pop_front());
          end
        end
      end
      if (!done) begin
        in_valid = (idx < n);
        in_data  = (idx < n) ? bytes[idx] : 8'h00;
        in_last  = (idx == n - 1);
        #1;
        if (in_valid && in_ready) begin
          idx++;
          started = 1'b1;
        end
      end else begin
        in_valid = 1'b0;
      end
    end
    in_valid = 1'b0;
    check(bad_ready == 0, "R11", "ready while line low", bad_ready, 0);
    check(in_ready == 1'b1, "R11", "ready when idle", in_ready, 1);
  endtask

  initial begin
    void'($urandom(32'd1446));
    rst_n = 1'b0; fc_en = 1'b1; in_valid = 1'b0; in_data = 8'h00; in_last = 1'b0;
    cfg_no_sof = 1'b0; cfg_no_eof = 1'b0; cfg_wide = 1'b0; cfg_adjust = 1'b0; cfg_egt = 2'b00;
    repeat (3) @(negedge clk);
    check(tx_out == 1'b1, "R1", "reset line", tx_out, 1);
    check(busy == 1'b0, "R1", "reset busy", busy, 0);
    check(in_ready == 1'b1, "R1", "reset ready", in_ready, 1);
    check(cfg_err == 1'b0, "R1", "reset config error", cfg_err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_out == 1'b1 && busy == 1'b0, "R1", "idle after reset", busy, 0);

    set_cfg(1'b0, 1'b0, 1'b0, 1'b0, 2'b00); if (!wd_hit) run_frame(2, 1'b0); // R4, R2
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'b11); if (!wd_hit) run_frame(2, 1'b0); // R5, R3
    set_cfg(1'b0, 1'b0, 1'b1, 1'b1, 2'b01); if (!wd_hit) run_frame(1, 1'b0); // R6
    set_cfg(1'b0, 1'b0, 1'b0, 1'b1, 2'b10); if (!wd_hit) run_frame(1, 1'b0); // R7
    set_cfg(1'b1, 1'b1, 1'b1, 1'b0, 2'b10); if (!wd_hit) run_frame(2, 1'b0); // R8, R9
    set_cfg(1'b0, 1'b0, 1'b1, 1'b0, 2'b01); if (!wd_hit) run_frame(2, 1'b1); // R12
    for (int f = 0; f < 4; f++) begin
      if (!wd_hit) begin
        set_cfg(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom));
        run_frame(int'($urandom_range(1, 3)), 1'($urandom_range(0, 1)));
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule